// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block executes the move-peripheral instruction of a processor core. Given the instruction's opcode, its 16-bit displacement word, the value of the selected address register and the value of the selected data register, it moves either the low 16 bits or the full 32 bits of the data register to or from memory one byte at a time. The bytes land on every other address, so an 8-bit peripheral that sits on one byte lane of a 16-bit bus can be read or written as if it were a wide register.

The core presents an instruction with a one-cycle `start` while the block is idle. The block decodes the opcode, reports the register numbers it needs, and either flags the opcode as not its own or runs the byte sequence over a request/acknowledge memory port. A load returns the merged register value together with a one-cycle `done`. The register file, instruction fetch and bus-fault handling sit outside the block.

The sequencer has three states. IDLE waits for `start`. A claimed opcode takes IDLE to XFER, and an unclaimed one raises `illegal` and stays in IDLE. XFER holds one byte request open until it is acknowledged. An acknowledge that is not the last one moves to the next byte and stays in XFER. The final acknowledge takes XFER to DONE. DONE lasts one cycle and returns to IDLE. A synchronous reset forces IDLE from any state.

Top module: `altb_xfer`

## Requirements
- R1: A `start` in IDLE is claimed when (`opcode` AND 0xF138) equals 0x0108 and `feat_en` is 1. A claimed start raises `mem_req` in the next cycle. An unclaimed start raises `illegal` for exactly one cycle (the next one), issues no memory request, and leaves the block idle.
- R2: When `feat_en` is 0, every opcode is unclaimed, including one that matches the pattern.
- R3: The first byte address is `areg_val` plus `ext_word` sign-extended to 32 bits.
- R4: When `opcode` bit 6 is 1, the transfer has 4 byte requests. When it is 0, the transfer has 2 byte requests.
- R5: When `opcode` bit 7 is 1, the transfer is a store and every request has `mem_we` = 1. When it is 0, the transfer is a load and every request has `mem_we` = 0.
- R6: Bytes move most significant first. A store with n bytes sends `dreg_val` bits 8k+7:8k in step k, for k running from n-1 down to 0. Each address after the first is 2 more than the one before it.
- R7: On a load, the byte read in step k goes to `dreg_out` bits 8k+7:8k. On a 2-byte load, `dreg_out` bits 31:16 equal `dreg_val` bits 31:16.
- R8: At most one request is outstanding at a time. While `mem_req` is 1 and `mem_ack` is 0, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R9: `done` is 1 for exactly one cycle, in the cycle after the final acknowledge, and `mem_req` is 0 in that cycle.
- R10: After a store, `dreg_out` equals `dreg_val` as it was presented at `start`.
- R11: A synchronous reset abandons any transfer in progress. In the cycle after reset, `mem_req`, `busy`, `done` and `illegal` are all 0.
- R12: `dreg_sel` equals `opcode` bits 11:9, and `areg_sel` equals `opcode` bits 2:0, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feat_en | input | 1 | Enables recognition of the instruction |
| start | input | 1 | Presents an instruction; sampled only in IDLE |
| opcode | input | 16 | Instruction word |
| ext_word | input | 16 | Signed displacement word |
| areg_val | input | 32 | Value of the selected address register |
| dreg_val | input | 32 | Value of the selected data register |
| dreg_sel | output | 3 | Data register number decoded from the opcode |
| areg_sel | output | 3 | Address register number decoded from the opcode |
| mem_req | output | 1 | Byte request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Completes the current request |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse: opcode not claimed |
| dreg_out | output | 32 | Updated data register value, valid with `done` |

## Verification
The bench targets byte order and lane placement. A design that reverses the order, or shifts the load lanes by one, writes or reads the wrong byte at the first address, or drops the top byte of the result. It runs 2-byte loads to catch a design that clobbers the upper half of the register. It uses negative displacements to catch a missing sign extension, which would put the start address 64 KiB too high. It uses opcodes that differ from the pattern in one masked bit, and a matching opcode with the feature disabled, to catch over-eager decoding that would start a bus cycle. It applies acknowledge delays and a reset in the middle of a long transfer to catch a design that moves on before the acknowledge, or that keeps requesting after reset.

// File: rtl/altb_pkg.sv
package altb_pkg;

    localparam logic [15:0] OP_MASK  = 16'hF138;
    localparam logic [15:0] OP_MATCH = 16'h0108;
    localparam int          BIT_LONG  = 6;
    localparam int          BIT_STORE = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic       hit;
        logic       is_store;
        logic       is_long;
        logic [2:0] dnum;
        logic [2:0] anum;
    } op_dec_t;

endpackage

// File: rtl/altb_decode.sv
module altb_decode
    import altb_pkg::*;
(
    input  logic [15:0] opcode,
    input  logic        feat_en,
    output op_dec_t     dec
);

    always_comb begin
        dec.hit      = feat_en && ((opcode & OP_MASK) == OP_MATCH);
        dec.is_store = opcode[BIT_STORE];
        dec.is_long  = opcode[BIT_LONG];
        dec.dnum     = opcode[11:9];
        dec.anum     = opcode[2:0];
    end

endmodule

// File: rtl/altb_addr.sv
module altb_addr #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STRIDE = 2
) (
    input  logic              clk,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

    always_ff @(posedge clk) begin
        if (load) begin
            addr_q <= base + disp_ext;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(STRIDE);
        end
    end

endmodule

// File: rtl/altb_lane.sv
module altb_lane #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] init,
    input  logic [CNT_W-1:0]  sel,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    output logic [7:0]        rd_byte,
    output logic [DATA_W-1:0] data_q
);

    logic [LANES-1:0][7:0] bytes_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (load) begin
                bytes_q[g] <= init[g*8 +: 8];
            end else if (wr_en && (sel == CNT_W'(g))) begin
                bytes_q[g] <= wr_byte;
            end
        end
    end

    assign data_q = bytes_q;

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == CNT_W'(i)) begin
                rd_byte = bytes_q[i];
            end
        end
    end

endmodule

// File: rtl/altb_xfer.sv
module altb_xfer
    import altb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              feat_en,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [15:0]       ext_word,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [DATA_W-1:0] dreg_val,
    output logic [2:0]        dreg_sel,
    output logic [2:0]        areg_sel,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] dreg_out
);

    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(LANES / 2 - 1);

    seq_state_t       state_q, state_d;
    op_dec_t          dec;
    logic [CNT_W-1:0] cnt_q;
    logic             store_q;
    logic             illegal_q;
    logic             accept;
    logic             beat;
    logic             last;
    logic [7:0]       cur_byte;

    altb_decode u_dec (
        .opcode  (opcode),
        .feat_en (feat_en),
        .dec     (dec)
    );

    assign accept = (state_q == ST_IDLE) && start && dec.hit;
    assign beat   = (state_q == ST_XFER) && mem_ack;
    assign last   = (cnt_q == '0);

    altb_addr #(.ADDR_W(ADDR_W), .DISP_W(16), .STRIDE(2)) u_addr (
        .clk    (clk),
        .load   (accept),
        .step   (beat && !last),
        .base   (areg_val),
        .disp   (ext_word),
        .addr_q (mem_addr)
    );

    altb_lane #(.DATA_W(DATA_W)) u_lane (
        .clk     (clk),
        .load    (accept),
        .init    (dreg_val),
        .sel     (cnt_q),
        .wr_en   (beat && !store_q),
        .wr_byte (mem_rdata),
        .rd_byte (cur_byte),
        .data_q  (dreg_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= (state_q == ST_IDLE) && start && !dec.hit;
        end
    end

    // byte counter and direction
    always_ff @(posedge clk) begin
        if (accept) begin
            cnt_q   <= dec.is_long ? CNT_LONG : CNT_SHORT;
            store_q <= dec.is_store;
        end else if (beat && !last) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)        state_d = ST_XFER;
            ST_XFER: if (beat && last)  state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_we    = store_q;
        mem_wdata = cur_byte;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        illegal   = illegal_q;
        dreg_sel  = dec.dnum;
        areg_sel  = dec.anum;
    end

endmodule

// File: rtl/altb_chk.sv
module altb_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              illegal
);

    // R8: request fields hold until acknowledged
    p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R6: consecutive requests step the address by two
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req ||
                                  (mem_addr == $past(mem_addr) + ADDR_W'(2))));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done follows an acknowledged request, with no request open
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!mem_req && $past(mem_req && mem_ack)));

    // R1: an unclaimed opcode starts no bus activity
    p_illegal_idle_r1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_req && !busy));

    // R1: illegal is a single-cycle pulse
    p_illegal_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !illegal);

endmodule

bind altb_xfer altb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_altb_xfer.sv
`timescale 1ns/1ps
module sim_altb_xfer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        feat_en = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] ext_word = '0;
    logic [31:0] areg_val = '0;
    logic [31:0] dreg_val = '0;
    logic [2:0]  dreg_sel, areg_sel;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, illegal;
    logic [31:0] dreg_out;

    int nchk = 0;
    int nfail = 0;
    int delay = 0;
    int wcnt = 0;
    logic [40:0] exp_q[$];

    always #4 clk = ~clk;

    altb_xfer u0 (
        .clk(clk), .rst(rst), .feat_en(feat_en), .start(start),
        .opcode(opcode), .ext_word(ext_word), .areg_val(areg_val),
        .dreg_val(dreg_val), .dreg_sel(dreg_sel), .areg_sel(areg_sel),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal), .dreg_out(dreg_out)
    );

    function automatic logic [7:0] rd_of(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // memory responder and request monitor
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst && mem_req) begin
                if (wcnt != 0) begin
                    wcnt--;
                end else begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected request", mem_addr, 32'h0);
                    end else begin
                        logic [40:0] e;
                        e = exp_q.pop_front();
                        chk(mem_addr == e[39:8], "R3/R6 address", mem_addr, e[39:8]);
                        chk(mem_we == e[40], "R5 direction", {31'h0, mem_we}, {31'h0, e[40]});
                        if (e[40])
                            chk(mem_wdata == e[7:0], "R6 store byte",
                                {24'h0, mem_wdata}, {24'h0, e[7:0]});
                    end
                    mem_ack = 1'b1;
                    mem_rdata = rd_of(mem_addr);
                    wcnt = delay;
                end
            end
        end
    end

    function automatic logic [15:0] mk_op(input int d, input bit st,
                                          input bit lg, input int a);
        return 16'h0108 | 16'(d << 9) | (st ? 16'h0080 : 16'h0) |
               (lg ? 16'h0040 : 16'h0) | 16'(a);
    endfunction

    task automatic run_op(input logic [15:0] op, input logic [15:0] ext,
                          input logic [31:0] a, input logic [31:0] d,
                          input bit en, input int dly);
        bit          legal;
        int          n;
        logic [31:0] ad, res;
        legal = en && ((op & 16'hF138) == 16'h0108);
        n = op[6] ? 4 : 2;
        ad = a + {{16{ext[15]}}, ext};
        res = d;
        delay = dly;
        wcnt = dly;
        if (legal) begin
            for (int k = n - 1; k >= 0; k--) begin
                exp_q.push_back({op[7], ad, d[8*k +: 8]});
                if (!op[7]) res[8*k +: 8] = rd_of(ad);
                ad = ad + 32'd2;
            end
        end
        @(negedge clk);
        start = 1'b1; opcode = op; ext_word = ext;
        areg_val = a; dreg_val = d; feat_en = en;
        #1;
        chk(dreg_sel == op[11:9], "R12 dreg_sel", {29'h0, dreg_sel}, {29'h0, op[11:9]});
        chk(areg_sel == op[2:0], "R12 areg_sel", {29'h0, areg_sel}, {29'h0, op[2:0]});
        @(negedge clk);
        start = 1'b0;
        dreg_val = ~d;
        areg_val = ~a;
        if (!legal) begin
            chk(illegal == 1'b1, "R1/R2 illegal raised", {31'h0, illegal}, 32'h1);
            chk(mem_req == 1'b0 && busy == 1'b0, "R1/R2 no request",
                {30'h0, mem_req, busy}, 32'h0);
            @(negedge clk);
            chk(illegal == 1'b0, "R1 illegal pulse", {31'h0, illegal}, 32'h0);
            chk(mem_req == 1'b0, "R1 stays idle", {31'h0, mem_req}, 32'h0);
        end else begin
            chk(mem_req == 1'b1 && illegal == 1'b0, "R1 request follows start",
                {30'h0, mem_req, illegal}, 32'h2);
            for (int t = 0; t < 100 && !done; t++) @(negedge clk);
            chk(done == 1'b1, "R9 done seen", {31'h0, done}, 32'h1);
            chk(exp_q.size() == 0, "R4 byte count", exp_q.size(), 32'h0);
            if (op[7])
                chk(dreg_out == d, "R10 store keeps register", dreg_out, d);
            else
                chk(dreg_out == res, "R7 load result", dreg_out, res);
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
        end
        exp_q.delete();
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !busy && !done && !illegal, "R11 reset state",
            {28'h0, mem_req, busy, done, illegal}, 32'h0);

        // R4 R5 R6 word and long stores, R3 positive displacement
        run_op(mk_op(3, 1, 0, 5), 16'h0010, 32'h0000_8000, 32'hA1B2_C3D4, 1, 0);
        run_op(mk_op(0, 1, 1, 1), 16'h0004, 32'h0001_0000, 32'h1122_3344, 1, 2);
        // R7 word load keeps upper half, long load, R3 negative displacement
        run_op(mk_op(7, 0, 0, 2), 16'hFFF0, 32'h0002_0040, 32'hDEAD_BEEF, 1, 1);
        run_op(mk_op(4, 0, 1, 7), 16'h8000, 32'h0010_0001, 32'h0F0F_0F0F, 1, 0);
        run_op(mk_op(1, 0, 1, 3), 16'h7FFE, 32'hFFFF_FFF0, 32'h0000_0000, 1, 3);
        // R1 opcodes off the pattern in one masked bit
        run_op(16'h0100, 16'h0000, 32'h0, 32'h0, 1, 0);
        run_op(16'h01C8 | 16'h0010, 16'h0000, 32'h0, 32'h0, 1, 0);
        run_op(16'h1108, 16'h0000, 32'h0, 32'h0, 1, 0);
        // R2 matching opcode with the feature disabled
        run_op(mk_op(2, 1, 1, 4), 16'h0002, 32'h100, 32'h55AA_55AA, 0, 0);

        // R11 reset during a long store
        delay = 0; wcnt = 0;
        exp_q.push_back({1'b1, 32'h0000_0200, 8'h99});
        exp_q.push_back({1'b1, 32'h0000_0202, 8'h88});
        exp_q.push_back({1'b1, 32'h0000_0204, 8'h77});
        exp_q.push_back({1'b1, 32'h0000_0206, 8'h66});
        @(negedge clk);
        start = 1'b1; opcode = mk_op(5, 1, 1, 0); ext_word = 16'h0;
        areg_val = 32'h200; dreg_val = 32'h9988_7766; feat_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !busy && !done && !illegal, "R11 reset abandons transfer",
            {28'h0, mem_req, busy, done, illegal}, 32'h0);
        @(negedge clk);
        chk(!mem_req && !done, "R11 stays idle after reset",
            {30'h0, mem_req, done}, 32'h0);
        exp_q.delete();

        // after reset the block works again
        run_op(mk_op(6, 0, 0, 6), 16'h0001, 32'h0000_3000, 32'h7654_3210, 1, 0);

        finish_run();
    end

endmodule